// File: doc/BRIEF.md
# Multi-Stream Frame Readout Controller

This controller sets the readout timing of a multichannel sampled array once per sample period. Each period begins with a short load window. During it the array's data-shift clock is enabled, and an output register takes in one bit per cycle from each of several parallel daisy-chain streams. The period then continues with a longer serial window. There the array clock is held off so that no fast edges disturb acquisition and conversion, and the output register sends its whole content off-chip one bit per cycle.

The default build covers 96 channels of 10 bits read over three streams on a 40 MHz clock. That gives a 320-cycle load window and a 960-cycle serial window, so the period is 1280 cycles or 32 µs. The serial line carries 1280 bit slots per period. During the load window it passes through an auxiliary input, which gives 320 auxiliary slots per period. A one-cycle marker flags the first data bit of every frame.

Top module: `rdo_frame_ctrl`

## Requirements
- R1: The period is PERIOD = LOAD_CYCLES + FRAME_BITS cycles, where FRAME_BITS = CHANNELS*SAMPLE_BITS and LOAD_CYCLES = FRAME_BITS/NUM_STREAMS. Position 0 is the first cycle after reset is released, and the position wraps from PERIOD-1 back to 0.
- R2: `arr_clk_en` and `oreg_load` are high exactly at positions 0 to LOAD_CYCLES-1.
- R3: `oreg_shift` is high exactly at positions LOAD_CYCLES to PERIOD-1. Exactly one of `oreg_load` and `oreg_shift` is high in every cycle.
- R4: On each load cycle, stream k (bit k of `stream_in`) enters the low end of register slice k, which covers bits k*LOAD_CYCLES to k*LOAD_CYCLES+LOAD_CYCLES-1. The first bit taken in a period ends at the top of its slice.
- R5: At position LOAD_CYCLES+j, `sdo` shows bit FRAME_BITS-1-j of the register as it stood after loading. The frame therefore goes out MSB first, starting with the highest slice.
- R6: During the load window `sdo` equals `aux_in`. During the serial window `aux_in` has no effect on `sdo`.
- R7: `frame_start` is high for exactly one cycle per period, at position LOAD_CYCLES.
- R8: While reset is asserted the position is held at 0 and the register is cleared. After release, `frame_start` first rises LOAD_CYCLES cycles later.
- R9: Each new period fully replaces the previous frame, with no bits left over from it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Readout clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stream_in | input | NUM_STREAMS | Head bit of each daisy-chain stream |
| aux_in | input | 1 | Auxiliary bit sent during the load window |
| arr_clk_en | output | 1 | Enable for the array data-shift clock |
| oreg_load | output | 1 | Load window flag and register parallel-load control |
| oreg_shift | output | 1 | Serial window flag and register shift control; marks the quiet phase |
| sdo | output | 1 | Serial data out |
| frame_start | output | 1 | Marks the first data bit of a frame |

## Verification
The bench builds the block with CHANNELS=6, SAMPLE_BITS=2 and NUM_STREAMS=3. That gives a 4-cycle load window, a 12-bit frame and a 16-cycle period. With a period this short, every phase boundary, the wrap and every slice position are compared bit by bit over many successive frames. The frames include all-ones followed by all-zeros to expose leftover bits. The auxiliary input is driven against the data during the serial window, and reset is applied mid-frame.

// File: rtl/rdo_frame_pkg.sv
package rdo_frame_pkg;
  function automatic int frame_bits(input int ch, input int bits);
    return ch * bits;
  endfunction

  function automatic int load_cycles(input int ch, input int bits, input int streams);
    return (ch * bits) / streams;
  endfunction

  function automatic int period_cycles(input int ch, input int bits, input int streams);
    return load_cycles(ch, bits, streams) + frame_bits(ch, bits);
  endfunction
endpackage

// File: rtl/rdo_phase_ctr.sv
module rdo_phase_ctr #(
  parameter int LOAD_CYCLES = 320,
  parameter int PERIOD      = 1280,
  localparam int CNT_W      = $clog2(PERIOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] pos,
  output logic             in_load,
  output logic             at_frame_start,
  output logic             at_wrap
);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(PERIOD - 1);
  localparam logic [CNT_W-1:0] SPLIT = CNT_W'(LOAD_CYCLES);

  assign at_wrap        = (pos == LAST);
  assign in_load        = (pos < SPLIT);
  assign at_frame_start = (pos == SPLIT);

  always_ff @(posedge clk) begin
    if (!rst_n)       pos <= '0;
    else if (at_wrap) pos <= '0;
    else              pos <= pos + 1'b1;
  end
endmodule

// File: rtl/rdo_out_reg.sv
module rdo_out_reg #(
  parameter int NUM_STREAMS = 3,
  parameter int SLICE_W     = 320,
  localparam int TOTAL_W    = NUM_STREAMS * SLICE_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   load,
  input  logic                   shift,
  input  logic [NUM_STREAMS-1:0] din,
  output logic                   msb,
  output logic                   next_msb
);
  logic [TOTAL_W-1:0] oreg;
  logic [TOTAL_W-1:0] loaded;

  genvar k;
  generate
    for (k = 0; k < NUM_STREAMS; k++) begin : g_slice
      assign loaded[k*SLICE_W +: SLICE_W] = {oreg[k*SLICE_W +: SLICE_W-1], din[k]};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)     oreg <= '0;
    else if (load)  oreg <= loaded;
    else if (shift) oreg <= {oreg[TOTAL_W-2:0], 1'b0};
  end

  assign msb      = oreg[TOTAL_W-1];
  assign next_msb = oreg[TOTAL_W-2];
endmodule

// File: rtl/rdo_frame_ctrl.sv
module rdo_frame_ctrl
  import rdo_frame_pkg::*;
#(
  parameter int CHANNELS     = 96,
  parameter int SAMPLE_BITS  = 10,
  parameter int NUM_STREAMS  = 3,
  localparam int FRAME_BITS  = frame_bits(CHANNELS, SAMPLE_BITS),
  localparam int LOAD_CYCLES = load_cycles(CHANNELS, SAMPLE_BITS, NUM_STREAMS),
  localparam int PERIOD      = period_cycles(CHANNELS, SAMPLE_BITS, NUM_STREAMS),
  localparam int CNT_W       = $clog2(PERIOD)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_STREAMS-1:0] stream_in,
  input  logic                   aux_in,
  output logic                   arr_clk_en,
  output logic                   oreg_load,
  output logic                   oreg_shift,
  output logic                   sdo,
  output logic                   frame_start
);
  logic [CNT_W-1:0] pos;
  logic in_load, at_fs, at_wrap;
  logic reg_msb, reg_next_msb;

  rdo_phase_ctr #(.LOAD_CYCLES(LOAD_CYCLES), .PERIOD(PERIOD)) u_ctr (
    .clk(clk), .rst_n(rst_n), .pos(pos), .in_load(in_load),
    .at_frame_start(at_fs), .at_wrap(at_wrap)
  );

  rdo_out_reg #(.NUM_STREAMS(NUM_STREAMS), .SLICE_W(LOAD_CYCLES)) u_oreg (
    .clk(clk), .rst_n(rst_n), .load(in_load), .shift(!in_load),
    .din(stream_in), .msb(reg_msb), .next_msb(reg_next_msb)
  );

  assign arr_clk_en  = in_load;
  assign oreg_load   = in_load;
  assign oreg_shift  = !in_load;
  assign frame_start = at_fs;
  assign sdo         = in_load ? aux_in : reg_msb;
endmodule

// File: rtl/rdo_frame_ctrl_chk.sv
module rdo_frame_ctrl_chk #(
  parameter int PERIOD = 1280,
  parameter int CNT_W  = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] pos,
  input logic             at_wrap,
  input logic             reg_next_msb,
  input logic             aux_in,
  input logic             arr_clk_en,
  input logic             oreg_load,
  input logic             oreg_shift,
  input logic             sdo,
  input logic             frame_start
);
  a_r1_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    at_wrap |=> (pos == '0));
  a_r2_gate_window: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(arr_clk_en) |-> frame_start);
  a_r3_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot({oreg_load, oreg_shift}));
  a_r5_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
    (oreg_shift && !frame_start) |-> (sdo == $past(reg_next_msb)));
  a_r6_aux_pass: assert property (@(posedge clk) disable iff (!rst_n)
    oreg_load |-> (sdo == aux_in));
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  a_r7_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> ($past(oreg_load) && oreg_shift));
endmodule

bind rdo_frame_ctrl rdo_frame_ctrl_chk #(.PERIOD(PERIOD), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pos(pos), .at_wrap(at_wrap),
  .reg_next_msb(reg_next_msb), .aux_in(aux_in), .arr_clk_en(arr_clk_en),
  .oreg_load(oreg_load), .oreg_shift(oreg_shift), .sdo(sdo),
  .frame_start(frame_start)
);

// File: tb/tb_rdo_frame_ctrl.sv
module tb_rdo_frame_ctrl;
  localparam int CH = 6, SB = 2, NS = 3;
  localparam int N  = CH * SB;
  localparam int L  = N / NS;
  localparam int P  = L + N;
  localparam int NV = 8;
  localparam logic [N-1:0] VEC [NV] = '{
    12'hA5C, 12'hFFF, 12'h000, 12'h801, 12'h001, 12'h3C6, 12'hFFF, 12'h5A3
  };

  logic clk = 0, rst_n = 0, aux_in = 0;
  logic [NS-1:0] stream_in;
  logic arr_clk_en, oreg_load, oreg_shift, sdo, frame_start;
  int n_cmp = 0, n_bad = 0;
  int ptr = 0, pidx = 0;
  logic [N-1:0] cur;

  always #2 clk = ~clk;

  rdo_frame_ctrl #(.CHANNELS(CH), .SAMPLE_BITS(SB), .NUM_STREAMS(NS)) dut (
    .clk(clk), .rst_n(rst_n), .stream_in(stream_in), .aux_in(aux_in),
    .arr_clk_en(arr_clk_en), .oreg_load(oreg_load), .oreg_shift(oreg_shift),
    .sdo(sdo), .frame_start(frame_start)
  );

  // chain model: each stream gives the top bit of its slice first
  assign cur = VEC[pidx % NV];
  always_comb
    for (int k = 0; k < NS; k++) stream_in[k] = cur[k*L + (L-1-ptr)];

  always @(posedge clk) begin
    if (!rst_n) begin
      ptr <= 0; pidx <= 0;
    end else if (arr_clk_en) begin
      if (ptr == L-1) begin ptr <= 0; pidx <= pidx + 1; end
      else ptr <= ptr + 1;
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    fork
      begin : wd
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
      begin : run
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 reset state
        chk(arr_clk_en, 1'b1, "R8 reset arr_clk_en");
        chk(oreg_load, 1'b1, "R8 reset oreg_load");
        chk(frame_start, 1'b0, "R8 reset frame_start");
        rst_n = 1;
        // table walk: one vector per period
        for (int v = 0; v < NV; v++) begin
          for (int p = 0; p < P; p++) begin
            aux_in = (p < L) ? logic'((p + v) & 1) : ~VEC[v][N-1-(p-L)];
            #1;
            chk(arr_clk_en, logic'(p < L), "R2 arr_clk_en window");
            chk(oreg_load,  logic'(p < L), "R2 oreg_load window");
            chk(oreg_shift, logic'(p >= L), "R3 oreg_shift window");
            chk(frame_start, logic'(p == L), "R7 frame_start position");
            if (p < L) chk(sdo, aux_in, "R6 aux passthrough");
            else chk(sdo, VEC[v][N-1-(p-L)], "R4 R5 R9 R6 serial frame bit");
            if (p == P-1) chk(oreg_shift, 1'b1, "R1 last cycle of period");
            @(negedge clk);
          end
          chk(oreg_load, 1'b1, "R1 wrap to load");
        end
        // directed: reset in the middle of the serial window
        repeat (L + 3) @(negedge clk);
        rst_n = 0;
        @(negedge clk);
        #1;
        chk(oreg_load, 1'b1, "R8 reset mid-frame");
        chk(frame_start, 1'b0, "R8 no marker in reset");
        rst_n = 1;
        for (int c = 0; c < L; c++) begin
          #1; chk(frame_start, 1'b0, "R8 marker not early");
          @(negedge clk);
        end
        #1;
        chk(frame_start, 1'b1, "R8 marker after load window");
        chk(sdo, VEC[0][N-1], "R5 first bit after reset");
        disable wd;
      end
    join
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule